// File: doc/BRIEF.md
# Read-Protected Cipher Key Register File

This block holds a 256-bit cipher key as eight 32-bit words that software writes over a simple register bus. A cipher datapath next to it takes the whole key as one wide vector, with key word 7 in the most significant position and word 0 in the least significant. A control word at address 0 carries a protect flag, a 5-bit unlock field and a 2-bit key-size selector.

Once software sets the protect flag, the key is hidden. Bus reads of the key words return zero, and bus writes to them are discarded. The key still reaches the datapath unchanged. Only one event releases protection: a control write with the protect bit at 0 and the unlock field at binary 10110. That same write erases every key word. While the engine reports busy, control writes and key writes are both discarded, so the key and its settings cannot change during an operation.

Top module: `key_file_top`

## Requirements
- R1: After reset, protectOn is 0, keySize is 0, keyOut is all zeros, and a read of the control word returns 0.
- R2: Key word i sits at bus address 8+i. When protection is off, a write there stores the data, a read returns it, and keyOut carries word i in bits 32*i+31 down to 32*i.
- R3: A control write (address 0) accepted while not busy with bit 31 at 1 sets protection. Bit 31 of the control read and protectOn then read 1 from the cycle after the write.
- R4: While protection is set, a read of any key address returns all zeros.
- R5: While protection is set, writes to key addresses leave the stored key unchanged.
- R6: A control write accepted while not busy, with bit 31 at 0 and bits 30:26 equal to 10110, clears protection and sets every key word to zero in the next cycle.
- R7: A control write with bit 31 at 0 and any other value in bits 30:26 leaves both the protection state and the key unchanged.
- R8: While engineBusy is 1, control writes are ignored. Protection, the unlock field and the key-size field all keep their values.
- R9: When not busy, a control write stores bits 3:2 as the key size. The value appears on keySize and in bits 3:2 of the control read. The value 2 selects a 256-bit key.
- R10: While engineBusy is 1, writes to key addresses leave the key unchanged.
- R11: Addresses 1 to 7 read as zero, and writes to them change neither the key nor the control state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| engineBusy | input | 1 | Cipher engine busy; blocks control and key updates |
| busWe | input | 1 | Bus write strobe for this cycle |
| busAddr | input | 4 | Word address: 0 control, 8..15 key words 0..7 |
| busWdata | input | 32 | Bus write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| keyOut | output | 256 | Full key to the cipher datapath, word 7 most significant |
| keySize | output | 2 | Stored key-size selector |
| protectOn | output | 1 | Current read-protection state |

## Verification
The bench sweeps all 32 values of the unlock field against a protected, loaded key. A design that compares too few bits would unlock, or wipe the key, on the wrong code. A design that forgets the wipe would leave the old key in place after a correct unlock. Each pass also tries a key overwrite while protected and a correct unlock while busy. Designs that let either one through would show a changed keyOut or a cleared protect flag. The key-size sweep, with and without busy, catches a field stored from the wrong bits or updated during an operation.

// File: rtl/key_file_pkg.sv
package key_file_pkg;
  parameter int WORD_W     = 32;
  parameter int KEY_WORDS  = 8;
  parameter int IDX_W      = $clog2(KEY_WORDS);
  parameter int ADDR_W     = IDX_W + 1;
  parameter int KEY_W      = WORD_W * KEY_WORDS;
  parameter int PROT_BIT   = 31;
  parameter int UNLK_W     = 5;
  parameter int UNLK_LO    = 26;
  parameter int KSZ_W      = 2;
  parameter int KSZ_LO     = 2;
  parameter logic [UNLK_W-1:0] UNLOCK_CODE = 5'b10110;
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = '0;

  typedef struct packed {
    logic             keyWe;
    logic [IDX_W-1:0] keyIdx;
    logic             wipe;
    logic             maskRead;
  } keyStrobeT;
endpackage

// File: rtl/key_prot_ctrl.sv
module key_prot_ctrl
  import key_file_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              engineBusy,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              protBitIn,
  input  logic [UNLK_W-1:0] unlockIn,
  input  logic [KSZ_W-1:0]  sizeIn,
  output keyStrobeT         strobes,
  output logic [WORD_W-1:0] ctrlImage,
  output logic [KSZ_W-1:0]  keySize,
  output logic              protectOn
);
  logic              ctrlWrite;
  logic              keyRegion;
  logic              unlockHit;
  logic              protectQ;
  logic [UNLK_W-1:0] unlockQ;
  logic [KSZ_W-1:0]  sizeQ;

  // control writes count only when the engine is idle
  assign ctrlWrite = busWe && (busAddr == CTRL_ADDR) && !engineBusy;
  assign keyRegion = busAddr[ADDR_W-1];
  assign unlockHit = ctrlWrite && !protBitIn && (unlockIn == UNLOCK_CODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protectQ <= 1'b0;
      unlockQ  <= '0;
      sizeQ    <= '0;
    end else if (ctrlWrite) begin
      unlockQ <= unlockIn;
      sizeQ   <= sizeIn;
      if (protBitIn) begin
        protectQ <= 1'b1;
      end else if (unlockHit) begin
        protectQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.keyWe    = busWe && keyRegion && !engineBusy && !protectQ;
    strobes.keyIdx   = busAddr[IDX_W-1:0];
    strobes.wipe     = unlockHit;
    strobes.maskRead = protectQ;
  end

  always_comb begin
    ctrlImage = '0;
    ctrlImage[PROT_BIT] = protectQ;
    ctrlImage[UNLK_LO +: UNLK_W] = unlockQ;
    ctrlImage[KSZ_LO +: KSZ_W] = sizeQ;
  end

  assign keySize   = sizeQ;
  assign protectOn = protectQ;
endmodule

// File: rtl/key_word_bank.sv
module key_word_bank
  import key_file_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  keyStrobeT         strobes,
  input  logic [WORD_W-1:0] busWdata,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] ctrlImage,
  output logic [WORD_W-1:0] busRdata,
  output logic [KEY_W-1:0]  keyOut
);
  logic [WORD_W-1:0] words [KEY_WORDS];

  for (genvar i = 0; i < KEY_WORDS; i++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        words[i] <= '0;
      end else if (strobes.wipe) begin
        words[i] <= '0;
      end else if (strobes.keyWe && (strobes.keyIdx == IDX_W'(i))) begin
        words[i] <= busWdata;
      end
    end
    assign keyOut[i*WORD_W +: WORD_W] = words[i];
  end

  always_comb begin
    if (busAddr == CTRL_ADDR) begin
      busRdata = ctrlImage;
    end else if (busAddr[ADDR_W-1] && !strobes.maskRead) begin
      busRdata = words[busAddr[IDX_W-1:0]];
    end else begin
      busRdata = '0;
    end
  end
endmodule

// File: rtl/key_file_top.sv
module key_file_top
  import key_file_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              engineBusy,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic [KEY_W-1:0]  keyOut,
  output logic [KSZ_W-1:0]  keySize,
  output logic              protectOn
);
  keyStrobeT         strobes;
  logic [WORD_W-1:0] ctrlImage;

  key_prot_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .engineBusy(engineBusy),
    .busWe     (busWe),
    .busAddr   (busAddr),
    .protBitIn (busWdata[PROT_BIT]),
    .unlockIn  (busWdata[UNLK_LO +: UNLK_W]),
    .sizeIn    (busWdata[KSZ_LO +: KSZ_W]),
    .strobes   (strobes),
    .ctrlImage (ctrlImage),
    .keySize   (keySize),
    .protectOn (protectOn)
  );

  key_word_bank u_bank (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .busAddr  (busAddr),
    .ctrlImage(ctrlImage),
    .busRdata (busRdata),
    .keyOut   (keyOut)
  );
endmodule

// File: rtl/key_file_chk.sv
module key_file_chk
  import key_file_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              engineBusy,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [WORD_W-1:0] busWdata,
  input logic [WORD_W-1:0] busRdata,
  input logic [KEY_W-1:0]  keyOut,
  input logic [KSZ_W-1:0]  keySize,
  input logic              protectOn
);
  logic ctrlWr;
  logic keyWr;
  assign ctrlWr = busWe && (busAddr == CTRL_ADDR);
  assign keyWr  = busWe && busAddr[ADDR_W-1];

  assert_set_protect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !engineBusy && busWdata[PROT_BIT]) |=> protectOn);

  assert_masked_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (protectOn && busAddr[ADDR_W-1]) |-> (busRdata == '0));

  assert_locked_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (protectOn && keyWr) |=> $stable(keyOut));

  assert_unlock_wipe_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !engineBusy && !busWdata[PROT_BIT] &&
     busWdata[UNLK_LO +: UNLK_W] == UNLOCK_CODE) |=> (!protectOn && keyOut == '0));

  assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !busWdata[PROT_BIT] && busWdata[UNLK_LO +: UNLK_W] != UNLOCK_CODE)
    |=> ($stable(protectOn) && $stable(keyOut)));

  assert_busy_ctrl_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && engineBusy) |=> ($stable(protectOn) && $stable(keySize) && $stable(keyOut)));

  assert_busy_key_R10: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && engineBusy) |=> $stable(keyOut));
endmodule

bind key_file_top key_file_chk u_chk (
  .clk(clk), .rstN(rstN), .engineBusy(engineBusy), .busWe(busWe),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .keyOut(keyOut), .keySize(keySize), .protectOn(protectOn)
);

// File: tb/key_file_top_tb.sv
module key_file_top_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         engineBusy = 1'b0;
  logic         busWe = 1'b0;
  logic [3:0]   busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [255:0] keyOut;
  logic [1:0]   keySize;
  logic         protectOn;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  key_file_top u_dut (
    .clk(clk), .rstN(rstN), .engineBusy(engineBusy), .busWe(busWe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .keyOut(keyOut), .keySize(keySize), .protectOn(protectOn)
  );

  function automatic logic [31:0] pat(int s, int i);
    return 32'h5A00_0001 + 32'(s) * 32'h0001_0000 + 32'(i) * 32'h0000_0101;
  endfunction

  function automatic logic [255:0] patKey(int s);
    logic [255:0] k;
    for (int i = 0; i < 8; i++) k[i*32 +: 32] = pat(s, i);
    return k;
  endfunction

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic busy);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d; engineBusy = busy;
    @(negedge clk);
    busWe = 1'b0; engineBusy = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic loadKey(int s);
    for (int i = 0; i < 8; i++) wr(4'(8 + i), pat(s, i), 1'b0);
  endtask

  initial begin
    logic [31:0] r;
    logic [255:0] k;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, r);
    check("R1 ctrl", 256'(r), 256'd0);
    check("R1 keyOut", keyOut, 256'd0);
    check("R1 protect", 256'(protectOn), 256'd0);
    check("R1 keySize", 256'(keySize), 256'd0);

    // R2 key map, read-back and concatenation
    loadKey(40);
    for (int i = 0; i < 8; i++) begin
      rd(4'(8 + i), r);
      check("R2 read", 256'(r), 256'(pat(40, i)));
    end
    check("R2 keyOut", keyOut, patKey(40));

    // R11 unused addresses
    for (int a = 1; a < 8; a++) begin
      wr(4'(a), 32'hFFFF_FFFF, 1'b0);
      rd(4'(a), r);
      check("R11 read", 256'(r), 256'd0);
    end
    check("R11 keyOut", keyOut, patKey(40));
    rd(4'd0, r);
    check("R11 ctrl", 256'(r), 256'd0);

    // R10 busy key write
    wr(4'd9, 32'hDEAD_BEEF, 1'b1);
    check("R10 keyOut", keyOut, patKey(40));

    // R9 / R8 key-size sweep
    for (int s = 0; s < 4; s++) begin
      wr(4'd0, 32'(s) << 2, 1'b0);
      check("R9 keySize", 256'(keySize), 256'(s));
      rd(4'd0, r);
      check("R9 ctrl", 256'(r), 256'(32'(s) << 2));
      wr(4'd0, (32'(3 - s) << 2) | 32'h8000_0000, 1'b1);
      check("R8 keySize", 256'(keySize), 256'(s));
      check("R8 protect", 256'(protectOn), 256'd0);
    end

    // main sweep over all unlock codes
    for (int c = 0; c < 32; c++) begin
      wr(4'd0, (32'd22 << 26) | 32'h8, 1'b0);
      loadKey(c);
      wr(4'd0, 32'h8000_0008, 1'b0);
      check("R3 protectOn", 256'(protectOn), 256'd1);
      rd(4'd0, r);
      check("R3 ctrl bit31", 256'(r[31]), 256'd1);
      rd(4'(8 + (c % 8)), r);
      check("R4 masked", 256'(r), 256'd0);
      wr(4'(8 + (c % 8)), 32'h1234_5678, 1'b0);
      check("R5 keyOut", keyOut, patKey(c));
      wr(4'd0, (32'd22 << 26) | 32'h8, 1'b1);
      check("R8 busy unlock", 256'(protectOn), 256'd1);
      check("R8 busy keyOut", keyOut, patKey(c));
      wr(4'd0, (32'(c) << 26) | 32'h8, 1'b0);
      if (c == 22) begin
        check("R6 protect", 256'(protectOn), 256'd0);
        check("R6 wipe", keyOut, 256'd0);
        rd(4'd8, r);
        check("R6 read", 256'(r), 256'd0);
      end else begin
        check("R7 protect", 256'(protectOn), 256'd1);
        check("R7 keyOut", keyOut, patKey(c));
      end
      check("R9 size kept", 256'(keySize), 256'd2);
    end

    // R2 again after unlock: writable and readable
    wr(4'd0, (32'd22 << 26) | 32'h8, 1'b0);
    wr(4'd15, 32'hCAFE_F00D, 1'b0);
    rd(4'd15, r);
    check("R2 after unlock", 256'(r), 256'h0000_0000_CAFE_F00D);
    k = '0; k[255:224] = 32'hCAFE_F00D;
    check("R2 msb word", keyOut, k);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule